// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads first-level and, where needed, second-level descriptors from memory through a single-beat read request and response port. The caller presents one request at a time with the virtual address, an access kind (read, write or execute), a user-mode flag, a translation-enable bit and the table base. The block answers with a one-cycle result strobe. The result carries the physical address, the read/write/execute permission bits, a large-page flag and a fault code.

The first level maps a 4 MB region directly or points to a second-level table of 4 KB pages. Two cases skip the table walk. When translation is off, the address passes through unchanged. When translation is on and a supervisor accesses the lower half of the space, the access goes to an I/O window in the upper half. Permission checks apply only to user accesses, and each violated permission has its own code. Every fault records the code and the virtual address in two holding registers. Each fault also raises either an instruction-trap flag (execute accesses) or a data-trap flag (all other accesses).

Top module: `pgwalk_top`

## Requirements
- R1: With `mmuEnable` low, the result has `resPaddr` equal to the request address, `resPerm` = 3'b111, `resBigPage` = 0 and `resFault` = 0, and no memory read is issued.
- R2: With `mmuEnable` high, a supervisor request (`reqUser` = 0) with address bit 31 clear issues no memory read and returns the address with bit 31 forced to 1, `resPerm` = 3'b111, `resBigPage` = 0 and no fault.
- R3: Every other request reads the first-level descriptor at {tableBase[31:12], va[31:22], 2'b00}. Each read request is a one-cycle `memReqValid` pulse, and the response is taken in the first cycle after it in which `memRespValid` is high.
- R4: A descriptor's type is its bits [1:0] and its present flag is bit 2. A first-level type 3 marks a 4 MB page. If present, it maps to {desc[31:22], va[21:0]} with `resBigPage` = 1. If not present, the fault code is 0x0B.
- R5: A first-level type 0 points to a second-level table. If it is not present, the fault code is 0x05. If it is present, the second read goes to {desc[31:12], va[21:12], 2'b00}.
- R6: A second-level descriptor that is not present gives fault code 0x08. One that is present with type 0 maps to {desc[31:12], va[11:0]} with `resBigPage` = 0.
- R7: A first-level type of 1 or 2, or a present second-level descriptor with a nonzero type, gives fault code `BAD_TYPE_CODE` (default 0x1F).
- R8: `resPerm` is {desc[8] read, desc[7] write, desc[6] exec} of the final descriptor. The access code is 0 for read, 1 for write, 2 for execute, and 3 is never checked. For user requests only, a missing read, write or execute permission gives 0x11, 0x12 or 0x13 respectively.
- R9: A nonzero `resFault` comes with `faultStatus` = code and `faultAddr` = virtual address. `trapInstr` is high for execute and `trapData` for any other access. On a fault, `resPaddr`, `resPerm` and `resBigPage` read 0. Without a fault both trap flags are low and the holding registers keep their values.
- R10: `resValid` is a single-cycle pulse per accepted request. `reqReady` is high only while idle, and requests presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Walker idle, request is taken this cycle |
| reqVaddr | input | 32 | Virtual address |
| reqAccess | input | 2 | 0 read, 1 write, 2 execute |
| reqUser | input | 1 | User-mode access |
| mmuEnable | input | 1 | Translation enable |
| tableBase | input | 32 | First-level table base (bits 31:12 used) |
| memReqValid | output | 1 | Descriptor read request |
| memReqAddr | output | 32 | Descriptor address |
| memRespValid | input | 1 | Descriptor read data valid |
| memRespData | input | 32 | Descriptor word |
| resValid | output | 1 | Result strobe |
| resPaddr | output | 32 | Physical address |
| resPerm | output | 3 | {read, write, exec} |
| resBigPage | output | 1 | 1 for a 4 MB mapping |
| resFault | output | 5 | Fault code, 0 for success |
| faultStatus | output | 5 | Code of the last fault |
| faultAddr | output | 32 | Virtual address of the last fault |
| trapInstr | output | 1 | Last result faulted on an execute access |
| trapData | output | 1 | Last result faulted on a non-execute access |

## Verification
The bound checker watches every result. On each cycle it checks the pass-through and I/O mappings, the offset bits of large pages, and the absence of permission faults for supervisors. It also checks that the holding registers and the trap kind agree with each reported fault, and that read requests and result strobes are single cycles issued only while busy. It cannot check descriptor address formation, the fault code for each descriptor shape, or the exact permission mapping, because those depend on memory contents. The bench covers them with a sweep over every access kind, mode, enable state, address half, descriptor shape and permission pattern, using varying response latency and stray requests while busy.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int ADDR_W = 32;
  localparam int PERM_W = 3;
  localparam int CODE_W = 5;
  localparam int LARGE_OFS_W = 22;
  localparam int PAGE_OFS_W = 12;
  localparam int IDX_W = 10;

  localparam int DESC_PRESENT = 2;
  localparam int DESC_RD = 8;

  localparam logic [1:0] TYPE_TABLE = 2'd0;
  localparam logic [1:0] TYPE_LARGE = 2'd3;

  localparam logic [1:0] ACC_EXEC = 2'd2;

  localparam logic [CODE_W-1:0] CODE_NONE = 5'h00;
  localparam logic [CODE_W-1:0] CODE_L1_MISS = 5'h05;
  localparam logic [CODE_W-1:0] CODE_L2_MISS = 5'h08;
  localparam logic [CODE_W-1:0] CODE_LARGE_MISS = 5'h0B;
  localparam logic [CODE_W-1:0] CODE_PERM_BASE = 5'h11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_CHECK, ST_DONE
  } walkState_t;

  typedef struct packed {
    logic capReq;
    logic capDesc;
    logic mapFlat;
    logic mapIo;
    logic mapLarge;
    logic mapPage;
    logic selL2;
    logic raiseFault;
    logic [CODE_W-1:0] code;
  } walkCtl_t;

  typedef struct packed {
    logic [1:0] respType;
    logic respPresent;
    logic permDeny;
    logic [CODE_W-1:0] permCode;
  } walkStat_t;
endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter logic [CODE_W-1:0] BAD_TYPE_CODE = 5'h1F
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqValid,
  input  logic      reqUser,
  input  logic      reqVaTop,
  input  logic      mmuEnable,
  input  logic      memRespValid,
  input  walkStat_t stat,
  output walkCtl_t  ctl,
  output logic      reqReady,
  output logic      memReqValid,
  output logic      resValid
);
  walkState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capReq = 1'b1;
          if (!mmuEnable) begin
            ctl.mapFlat = 1'b1;
            nextState = ST_DONE;
          end else if (!reqUser && !reqVaTop) begin
            ctl.mapIo = 1'b1;
            nextState = ST_DONE;
          end else begin
            nextState = ST_L1_REQ;
          end
        end
      end
      ST_L1_REQ: nextState = ST_L1_WAIT;
      ST_L1_WAIT: begin
        if (memRespValid) begin
          ctl.capDesc = 1'b1;
          if (stat.respType == TYPE_LARGE) begin
            if (stat.respPresent) begin
              ctl.mapLarge = 1'b1;
              nextState = ST_CHECK;
            end else begin
              ctl.raiseFault = 1'b1;
              ctl.code = CODE_LARGE_MISS;
              nextState = ST_DONE;
            end
          end else if (stat.respType == TYPE_TABLE) begin
            if (stat.respPresent) begin
              nextState = ST_L2_REQ;
            end else begin
              ctl.raiseFault = 1'b1;
              ctl.code = CODE_L1_MISS;
              nextState = ST_DONE;
            end
          end else begin
            ctl.raiseFault = 1'b1;
            ctl.code = BAD_TYPE_CODE;
            nextState = ST_DONE;
          end
        end
      end
      ST_L2_REQ: begin
        ctl.selL2 = 1'b1;
        nextState = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        ctl.selL2 = 1'b1;
        if (memRespValid) begin
          ctl.capDesc = 1'b1;
          if (!stat.respPresent) begin
            ctl.raiseFault = 1'b1;
            ctl.code = CODE_L2_MISS;
            nextState = ST_DONE;
          end else if (stat.respType != TYPE_TABLE) begin
            ctl.raiseFault = 1'b1;
            ctl.code = BAD_TYPE_CODE;
            nextState = ST_DONE;
          end else begin
            ctl.mapPage = 1'b1;
            nextState = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (stat.permDeny) begin
          ctl.raiseFault = 1'b1;
          ctl.code = stat.permCode;
        end
        nextState = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign memReqValid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign resValid = (state == ST_DONE);
endmodule

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  walkCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic              reqUser,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [ADDR_W-1:0] memRespData,
  output walkStat_t         stat,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] resPaddr,
  output logic [PERM_W-1:0] resPerm,
  output logic              resBigPage,
  output logic [CODE_W-1:0] resFault,
  output logic [CODE_W-1:0] faultStatus,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              trapInstr,
  output logic              trapData
);
  localparam int FRAME_W = ADDR_W - PAGE_OFS_W;
  localparam int LARGE_W = ADDR_W - LARGE_OFS_W;

  logic [ADDR_W-1:0] vaReg, descReg, paddrReg, faultAddrReg;
  logic [1:0]        accReg;
  logic              userReg, bigReg, trapIReg, trapDReg;
  logic [PERM_W-1:0] permReg;
  logic [CODE_W-1:0] codeReg, faultStatusReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaReg <= '0; descReg <= '0; paddrReg <= '0; faultAddrReg <= '0;
      accReg <= '0; userReg <= 1'b0; bigReg <= 1'b0;
      trapIReg <= 1'b0; trapDReg <= 1'b0;
      permReg <= '0; codeReg <= '0; faultStatusReg <= '0;
    end else begin
      if (ctl.capReq) begin
        vaReg <= reqVaddr;
        accReg <= reqAccess;
        userReg <= reqUser;
        codeReg <= CODE_NONE;
        trapIReg <= 1'b0;
        trapDReg <= 1'b0;
        bigReg <= 1'b0;
        permReg <= '0;
        paddrReg <= '0;
      end
      if (ctl.mapFlat) begin
        paddrReg <= reqVaddr;
        permReg <= '1;
      end
      if (ctl.mapIo) begin
        paddrReg <= {1'b1, reqVaddr[ADDR_W-2:0]};
        permReg <= '1;
      end
      if (ctl.capDesc) descReg <= memRespData;
      if (ctl.mapLarge) begin
        paddrReg <= {memRespData[ADDR_W-1 -: LARGE_W], vaReg[LARGE_OFS_W-1:0]};
        permReg <= memRespData[DESC_RD -: PERM_W];
        bigReg <= 1'b1;
      end
      if (ctl.mapPage) begin
        paddrReg <= {memRespData[ADDR_W-1 -: FRAME_W], vaReg[PAGE_OFS_W-1:0]};
        permReg <= memRespData[DESC_RD -: PERM_W];
        bigReg <= 1'b0;
      end
      if (ctl.raiseFault) begin
        codeReg <= ctl.code;
        faultStatusReg <= ctl.code;
        faultAddrReg <= vaReg;
        trapIReg <= (accReg == ACC_EXEC);
        trapDReg <= (accReg != ACC_EXEC);
      end
    end
  end

  // Descriptor addresses for both table levels
  logic [ADDR_W-1:0] l1Addr, l2Addr;
  assign l1Addr = {tableBase[ADDR_W-1 -: FRAME_W], vaReg[ADDR_W-1 -: IDX_W], 2'b00};
  assign l2Addr = {descReg[ADDR_W-1 -: FRAME_W], vaReg[LARGE_OFS_W-1 -: IDX_W], 2'b00};
  assign memReqAddr = ctl.selL2 ? l2Addr : l1Addr;

  // One deny term per access kind; kind k is guarded by descriptor bit DESC_RD-k
  logic [PERM_W-1:0] denyVec;
  for (genvar k = 0; k < PERM_W; k++) begin : g_perm
    assign denyVec[k] = userReg && (accReg == 2'(k)) && !descReg[DESC_RD-k];
  end

  always_comb begin
    stat.respType = memRespData[1:0];
    stat.respPresent = memRespData[DESC_PRESENT];
    stat.permDeny = |denyVec;
    stat.permCode = CODE_NONE;
    for (int k = 0; k < PERM_W; k++) begin
      if (denyVec[k]) stat.permCode = CODE_PERM_BASE + CODE_W'(k);
    end
  end

  logic unusedBits;
  assign unusedBits = ^{tableBase[PAGE_OFS_W-1:0], descReg[PAGE_OFS_W-1:DESC_RD+1],
                        descReg[DESC_RD-PERM_W:0]};

  logic okReg;
  assign okReg = (codeReg == CODE_NONE);
  assign resPaddr = okReg ? paddrReg : '0;
  assign resPerm = okReg ? permReg : '0;
  assign resBigPage = okReg && bigReg;
  assign resFault = codeReg;
  assign faultStatus = faultStatusReg;
  assign faultAddr = faultAddrReg;
  assign trapInstr = trapIReg;
  assign trapData = trapDReg;
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter logic [4:0] BAD_TYPE_CODE = 5'h1F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqVaddr,
  input  logic [1:0]  reqAccess,
  input  logic        reqUser,
  input  logic        mmuEnable,
  input  logic [31:0] tableBase,
  output logic        memReqValid,
  output logic [31:0] memReqAddr,
  input  logic        memRespValid,
  input  logic [31:0] memRespData,
  output logic        resValid,
  output logic [31:0] resPaddr,
  output logic [2:0]  resPerm,
  output logic        resBigPage,
  output logic [4:0]  resFault,
  output logic [4:0]  faultStatus,
  output logic [31:0] faultAddr,
  output logic        trapInstr,
  output logic        trapData
);
  walkCtl_t  ctl;
  walkStat_t stat;

  pgwalk_ctrl #(.BAD_TYPE_CODE(BAD_TYPE_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqUser(reqUser),
    .reqVaTop(reqVaddr[ADDR_W-1]), .mmuEnable(mmuEnable),
    .memRespValid(memRespValid), .stat(stat), .ctl(ctl),
    .reqReady(reqReady), .memReqValid(memReqValid), .resValid(resValid)
  );

  pgwalk_dp u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .reqUser(reqUser), .tableBase(tableBase),
    .memRespData(memRespData), .stat(stat), .memReqAddr(memReqAddr),
    .resPaddr(resPaddr), .resPerm(resPerm), .resBigPage(resBigPage),
    .resFault(resFault), .faultStatus(faultStatus), .faultAddr(faultAddr),
    .trapInstr(trapInstr), .trapData(trapData)
  );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqVaddr,
  input logic [1:0]  reqAccess,
  input logic        reqUser,
  input logic        mmuEnable,
  input logic        memReqValid,
  input logic        resValid,
  input logic [31:0] resPaddr,
  input logic [2:0]  resPerm,
  input logic        resBigPage,
  input logic [4:0]  resFault,
  input logic [4:0]  faultStatus,
  input logic [31:0] faultAddr,
  input logic        trapInstr,
  input logic        trapData
);
  logic [31:0] vaChk;
  logic [1:0]  accChk;
  logic        userChk, mmuChk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaChk <= '0; accChk <= '0; userChk <= 1'b0; mmuChk <= 1'b0;
    end else if (reqValid && reqReady) begin
      vaChk <= reqVaddr; accChk <= reqAccess; userChk <= reqUser; mmuChk <= mmuEnable;
    end
  end

  assert_flat_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && !mmuChk |-> resPaddr == vaChk && resPerm == 3'b111 && resFault == 5'h00);
  assert_no_read_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> mmuChk);
  assert_io_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && mmuChk && !userChk && !vaChk[31] |->
      resPaddr == {1'b1, vaChk[30:0]} && resPerm == 3'b111 && resFault == 5'h00);
  assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |=> !memReqValid);
  assert_large_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && resBigPage |-> resPaddr[21:0] == vaChk[21:0]);
  assert_sup_no_perm_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && !userChk |-> !(resFault >= 5'h11 && resFault <= 5'h13));
  assert_fault_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && resFault != 5'h00 |-> faultStatus == resFault && faultAddr == vaChk);
  assert_trap_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && resFault != 5'h00 |->
      trapInstr == (accChk == 2'd2) && trapData == (accChk != 2'd2));
  assert_no_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resValid && resFault == 5'h00 |-> !trapInstr && !trapData);
  assert_result_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |=> !resValid);
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid || resValid) |-> !reqReady);
endmodule

bind pgwalk_top pgwalk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
  .reqVaddr(reqVaddr), .reqAccess(reqAccess), .reqUser(reqUser),
  .mmuEnable(mmuEnable), .memReqValid(memReqValid), .resValid(resValid),
  .resPaddr(resPaddr), .resPerm(resPerm), .resBigPage(resBigPage),
  .resFault(resFault), .faultStatus(faultStatus), .faultAddr(faultAddr),
  .trapInstr(trapInstr), .trapData(trapData)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic        mmuEnable = 1'b0;
  logic [31:0] tableBase = 32'h0012_3ABC;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespData = '0;
  logic        resValid;
  logic [31:0] resPaddr;
  logic [2:0]  resPerm;
  logic        resBigPage;
  logic [4:0]  resFault;
  logic [4:0]  faultStatus;
  logic [31:0] faultAddr;
  logic        trapInstr;
  logic        trapData;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int rdCount = 0;
  int latency = 1;
  logic [31:0] rdAddr [0:3];
  logic [31:0] l1Desc = '0;
  logic [31:0] l2Desc = '0;
  logic [4:0]  expFs = '0;
  logic [31:0] expFa = '0;
  bit done = 1'b0;

  pgwalk_top u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .reqUser(reqUser),
    .mmuEnable(mmuEnable), .tableBase(tableBase), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRespValid(memRespValid), .memRespData(memRespData),
    .resValid(resValid), .resPaddr(resPaddr), .resPerm(resPerm),
    .resBigPage(resBigPage), .resFault(resFault), .faultStatus(faultStatus),
    .faultAddr(faultAddr), .trapInstr(trapInstr), .trapData(trapData)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Reference model written from the requirements
  task automatic model(input logic [31:0] va, input logic [1:0] acc, input bit user,
                       input bit mmu, output logic [31:0] pa, output logic [2:0] perm,
                       output bit big, output logic [4:0] code, output int reads);
    pa = '0; perm = '0; big = 1'b0; code = 5'h00; reads = 0;
    if (!mmu) begin
      pa = va; perm = 3'b111;
    end else if (!user && !va[31]) begin
      pa = va | 32'h8000_0000; perm = 3'b111;
    end else begin
      reads = 1;
      if (l1Desc[1:0] == 2'd3) begin
        if (!l1Desc[2]) code = 5'h0B;
        else begin
          pa = {l1Desc[31:22], va[21:0]}; perm = l1Desc[8:6]; big = 1'b1;
        end
      end else if (l1Desc[1:0] == 2'd0) begin
        if (!l1Desc[2]) code = 5'h05;
        else begin
          reads = 2;
          if (!l2Desc[2]) code = 5'h08;
          else if (l2Desc[1:0] != 2'd0) code = 5'h1F;
          else begin
            pa = {l2Desc[31:12], va[11:0]}; perm = l2Desc[8:6];
          end
        end
      end else code = 5'h1F;
      if (code == 5'h00 && user) begin
        if (acc == 2'd0 && !perm[2]) code = 5'h11;
        else if (acc == 2'd1 && !perm[1]) code = 5'h12;
        else if (acc == 2'd2 && !perm[0]) code = 5'h13;
      end
    end
    if (code != 5'h00) begin
      pa = '0; perm = '0; big = 1'b0;
    end
  endtask

  task automatic runTxn(input logic [31:0] va, input logic [1:0] acc, input bit user,
                        input bit mmu, input bit noise);
    logic [31:0] ePa; logic [2:0] ePerm; bit eBig; logic [4:0] eCode; int eReads;
    int waitCnt;
    bit got;
    model(va, acc, user, mmu, ePa, ePerm, eBig, eCode, eReads);
    rdCount = 0;
    reqVaddr = va; reqAccess = acc; reqUser = user; mmuEnable = mmu; reqValid = 1'b1;
    check(reqReady == 1'b1, "R10 ready while idle", 32'(reqReady), 32'd1);
    @(posedge clk);
    got = 1'b0;
    waitCnt = 0;
    while (!got && waitCnt < 60) begin
      @(negedge clk);
      waitCnt++;
      if (resValid) begin
        got = 1'b1;
        reqValid = 1'b0;
      end else begin
        reqValid = noise;
        reqVaddr = ~va;
        reqAccess = acc ^ 2'd1;
      end
    end
    if (!got) begin
      check(1'b0, "R10 result timeout", 32'd0, 32'd1);
      return;
    end
    check(resPaddr == ePa, "R1 R2 R4 R6 paddr", resPaddr, ePa);
    check(resPerm == ePerm, "R8 perm", 32'(resPerm), 32'(ePerm));
    check(resBigPage == eBig, "R4 big page", 32'(resBigPage), 32'(eBig));
    check(resFault == eCode, "R4 R5 R6 R7 R8 fault code", 32'(resFault), 32'(eCode));
    if (eCode != 5'h00) begin
      expFs = eCode; expFa = va;
    end
    check(faultStatus == expFs, "R9 fault status", 32'(faultStatus), 32'(expFs));
    check(faultAddr == expFa, "R9 fault address", faultAddr, expFa);
    check(trapInstr == (eCode != 0 && acc == 2'd2), "R9 instr trap",
          32'(trapInstr), 32'(eCode != 0 && acc == 2'd2));
    check(trapData == (eCode != 0 && acc != 2'd2), "R9 data trap",
          32'(trapData), 32'(eCode != 0 && acc != 2'd2));
    check(rdCount == eReads, "R1 R2 R3 R5 read count", 32'(rdCount), 32'(eReads));
    if (eReads >= 1)
      check(rdAddr[0] == {tableBase[31:12], va[31:22], 2'b00}, "R3 level-1 address",
            rdAddr[0], {tableBase[31:12], va[31:22], 2'b00});
    if (eReads >= 2)
      check(rdAddr[1] == {l1Desc[31:12], va[21:12], 2'b00}, "R5 level-2 address",
            rdAddr[1], {l1Desc[31:12], va[21:12], 2'b00});
    check(reqReady == 1'b0, "R10 busy at result", 32'(reqReady), 32'd0);
    @(negedge clk);
    check(resValid == 1'b0, "R10 single pulse", 32'(resValid), 32'd0);
  endtask

  // Descriptor memory: replies one or more cycles after each request
  initial begin
    forever begin
      @(negedge clk);
      while (memReqValid) begin
        if (rdCount < 4) rdAddr[rdCount] = memReqAddr;
        memRespData = (rdCount == 0) ? l1Desc : l2Desc;
        rdCount++;
        repeat (latency) @(negedge clk);
        memRespValid = 1'b1;
        @(negedge clk);
        memRespValid = 1'b0;
        memRespData = 32'hDEAD_BEEF;
      end
    end
  end

  // Watchdog
  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        check(1'b0, "R10 watchdog expired", 32'(cycles), 32'd190000);
        finishRun();
      end
    end
  end

  initial begin
    int txn;
    txn = 0;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R10 reset ready", 32'(reqReady), 32'd1);
    check(resValid == 1'b0, "R10 reset result", 32'(resValid), 32'd0);
    check(memReqValid == 1'b0, "R3 reset read", 32'(memReqValid), 32'd0);
    check(faultStatus == 5'h00, "R9 reset status", 32'(faultStatus), 32'd0);
    check(faultAddr == 32'h0, "R9 reset address", faultAddr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int l1k = 0; l1k < 6; l1k++) begin
      for (int l2k = 0; l2k < ((l1k == 3) ? 3 : 1); l2k++) begin
        for (int p = 0; p < 8; p++) begin
          case (l1k)
            0: l1Desc = {10'h2D3, 13'h0A5A, 3'(p), 3'b101, 1'b1, 2'b11};
            1: l1Desc = {10'h2D3, 13'h0A5A, 3'(p), 3'b101, 1'b0, 2'b11};
            2: l1Desc = {20'h00456, 3'b110, 3'(p), 3'b000, 1'b0, 2'b00};
            3: l1Desc = {20'h00456, 3'b110, 3'(p), 3'b000, 1'b1, 2'b00};
            4: l1Desc = {20'h00456, 3'b110, 3'(p), 3'b000, 1'b1, 2'b01};
            default: l1Desc = {20'h00456, 3'b110, 3'(p), 3'b000, 1'b1, 2'b10};
          endcase
          case (l2k)
            0: l2Desc = {20'h789AB, 3'b011, 3'(p), 3'b010, 1'b1, 2'b00};
            1: l2Desc = {20'h789AB, 3'b011, 3'(p), 3'b010, 1'b0, 2'b00};
            default: l2Desc = {20'h789AB, 3'b011, 3'(p), 3'b010, 1'b1, 2'b10};
          endcase
          for (int acc = 0; acc < 4; acc++) begin
            for (int mode = 0; mode < 8; mode++) begin
              logic [31:0] va;
              va = 32'(txn) * 32'h9E37_79B9 + 32'h0123_4567;
              va[31] = mode[2];
              latency = 1 + (txn % 3);
              runTxn(va, 2'(acc), mode[0], mode[1], (txn % 4) == 0);
              txn++;
            end
          end
        end
      end
    end
    done = 1'b1;
    finishRun();
  end
endmodule